// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous request port and an external static RAM that has no clock. A client issues one read or one write at a time with an address and, for writes, a data word. The controller then steps through a fixed sequence of clock-counted phases. During these phases it drives the memory's active-low select, active-high enable, active-low write strobe and active-low output enable. It also drives the address and the data-bus direction. For a read it captures the returned word in a register and raises `done` for one clock. For a write it raises `done` once the data hold interval has elapsed.

Every timing figure is a parameter counted in clock cycles. These are the read access time, the address setup before the write pulse, the pulse width, the address and data hold after the pulse, the recovery between pulses, the bus turn-off delay after a read, and the minimum write cycle. Each write carries a 2-bit selector that chooses which memory control forms the write pulse. The other two controls are held active around that pulse. After a read the chip stays selected with its output enabled, so a following read only changes the address. A following write first releases the chip for the turn-off delay.

Top module: `sram_ctl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, the memory is fully released: `mem_cs_n`=1, `mem_ce`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0, `done`=0 and `req_ready`=1.
- R2: A read drives `mem_cs_n`=0, `mem_ce`=1, `mem_we_n`=1, `mem_oe_n`=0. The word on `mem_dq_in` is captured exactly `ACC_CYC` cycles after the accepting edge, with the address held for that whole time. `done` is high for that one cycle only.
- R3: A read accepted while the previous read has left the chip open keeps `mem_cs_n` low and `mem_oe_n` low throughout; only `mem_addr` changes.
- R4: Selector code 0 (and the spare code 3) times the write with `mem_we_n`, code 1 with `mem_cs_n`, code 2 with `mem_ce`. In the cycle before the pulse the two non-timing controls are already active and the timing one is inactive.
- R5: The write pulse (`mem_cs_n`=0, `mem_ce`=1, `mem_we_n`=0 together) lasts exactly `WP_CYC` cycles.
- R6: The address is stable for at least `AS_CYC` cycles before the pulse and does not change during it.
- R7: `mem_dq_oe` rises together with the pulse. It stays high, with unchanged data, for exactly `AH_CYC` cycles after the pulse ends, and is never high while `mem_oe_n` is low.
- R8: In the first recovery cycle after a write, a write timed by `mem_cs_n` or `mem_ce` leaves the chip released (`mem_cs_n`=1, `mem_ce`=0). A write timed by `mem_we_n` keeps `mem_cs_n`=0 and `mem_ce`=1 with `mem_we_n`=1.
- R9: Between two write pulses at least `WR_CYC` cycles pass with the pulse inactive, and pulse starts are at least `WC_CYC` cycles apart.
- R10: When a write follows a read, at least `HZ_CYC` + `AS_CYC` cycles with `mem_oe_n`=1 and the bus undriven pass before `mem_dq_oe` rises.
- R11: The selector is sampled when the write is accepted; changing `req_wsel` later does not change the shape of that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; taken when `req_ready` is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wsel | input | 2 | Write timing control: 0/3 write strobe, 1 select, 2 enable |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Controller can take a request this cycle |
| done | output | 1 | One-cycle completion strobe |
| rd_data | output | DATA_W | Last word read |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_ce | output | 1 | Memory enable, active high |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_out | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | DATA_W | Data returned by the memory |

## Verification
The assertions assume that the timing parameters are all at least one cycle. They also assume that `req_valid` is presented with stable fields only while `req_ready` is high. Under these conditions the pulse, address and bus-direction relations are purely a matter of the controller's own sequencing. The stimulus waits for `req_ready` at the falling edge before raising a request and drops it after one accepting edge. The memory model returns a poison word unless the read address has been held long enough, so an early capture shows up as a data mismatch rather than passing silently.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [1:0] {
        WSEL_WE  = 2'd0,
        WSEL_CS  = 2'd1,
        WSEL_CE  = 2'd2,
        WSEL_ALT = 2'd3
    } wsel_e;

    typedef enum logic [2:0] {
        PH_OFF,
        PH_READ,
        PH_ARM,
        PH_PULSE,
        PH_RECOV
    } phase_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_OPEN,
        ST_READ,
        ST_TURN,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_WRECOV
    } state_e;

    typedef struct packed {
        logic cs_n;
        logic ce;
        logic we_n;
        logic oe_n;
    } pins_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Recovery length so that both the pulse gap and the full write cycle are met
    function automatic int recov_len(input int wr, input int ah, input int wc,
                                     input int as_c, input int wp);
        return max2(1, max2(wr - ah, wc - as_c - wp - ah));
    endfunction

    function automatic pins_t released();
        pins_t p;
        p.cs_n = 1'b1;
        p.ce   = 1'b0;
        p.we_n = 1'b1;
        p.oe_n = 1'b1;
        return p;
    endfunction

    function automatic pins_t arm_pins(input wsel_e sel);
        pins_t p;
        p.cs_n = 1'b0;
        p.ce   = 1'b1;
        p.we_n = 1'b0;
        p.oe_n = 1'b1;
        case (sel)
            WSEL_CS: p.cs_n = 1'b1;
            WSEL_CE: p.ce   = 1'b0;
            default: p.we_n = 1'b1;
        endcase
        return p;
    endfunction

    function automatic pins_t map_pins(input wsel_e sel, input phase_e ph);
        pins_t p;
        p = released();
        case (ph)
            PH_READ: begin
                p.cs_n = 1'b0;
                p.ce   = 1'b1;
                p.oe_n = 1'b0;
            end
            PH_ARM:   p = arm_pins(sel);
            PH_PULSE: begin
                p.cs_n = 1'b0;
                p.ce   = 1'b1;
                p.we_n = 1'b0;
            end
            PH_RECOV: begin
                if (sel == WSEL_CS || sel == WSEL_CE) p = released();
                else                                  p = arm_pins(WSEL_WE);
            end
            default: p = released();
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter int ACC_CYC = 4,
    parameter int AS_CYC  = 2,
    parameter int WP_CYC  = 3,
    parameter int AH_CYC  = 1,
    parameter int WR_CYC  = 3,
    parameter int HZ_CYC  = 3,
    parameter int WC_CYC  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  wsel_e             req_sel,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] dq_in,
    output logic              req_ready,
    output phase_e            phase,
    output wsel_e             sel_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              dq_oe,
    output logic              done,
    output logic [DATA_W-1:0] rd_data
);

    localparam int REC_CYC = recov_len(WR_CYC, AH_CYC, WC_CYC, AS_CYC, WP_CYC);
    localparam int MAX_D   = max2(max2(max2(ACC_CYC, HZ_CYC), max2(AS_CYC, WP_CYC)),
                                  max2(AH_CYC, REC_CYC));
    localparam int CNT_W   = $clog2(MAX_D + 1);

    state_e           state, state_n;
    logic             expired, load, accept;
    logic [CNT_W-1:0] load_val;

    function automatic logic [CNT_W-1:0] dur(input state_e s);
        case (s)
            ST_READ:   return CNT_W'(ACC_CYC - 1);
            ST_TURN:   return CNT_W'(HZ_CYC - 1);
            ST_WSETUP: return CNT_W'(AS_CYC - 1);
            ST_WPULSE: return CNT_W'(WP_CYC - 1);
            ST_WHOLD:  return CNT_W'(AH_CYC - 1);
            ST_WRECOV: return CNT_W'(REC_CYC - 1);
            default:   return '0;
        endcase
    endfunction

    assign req_ready = (state == ST_IDLE) || (state == ST_RD_OPEN);
    assign accept    = req_ready && req_valid;

    always_comb begin
        state_n = state;
        case (state)
            ST_IDLE:    if (req_valid) state_n = req_write ? ST_WSETUP : ST_READ;
            ST_RD_OPEN: if (req_valid) state_n = req_write ? ST_TURN : ST_READ;
            ST_READ:    if (expired) state_n = ST_RD_OPEN;
            ST_TURN:    if (expired) state_n = ST_WSETUP;
            ST_WSETUP:  if (expired) state_n = ST_WPULSE;
            ST_WPULSE:  if (expired) state_n = ST_WHOLD;
            ST_WHOLD:   if (expired) state_n = ST_WRECOV;
            ST_WRECOV:  if (expired) state_n = ST_IDLE;
            default:    state_n = ST_IDLE;
        endcase
        load     = (state_n != state);
        load_val = dur(state_n);
    end

    sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            sel_q   <= WSEL_WE;
            addr_q  <= '0;
            wdata_q <= '0;
            rd_data <= '0;
            done    <= 1'b0;
        end else begin
            state <= state_n;
            done  <= 1'b0;
            if (accept) begin
                addr_q <= req_addr;
                if (req_write) begin
                    wdata_q <= req_wdata;
                    sel_q   <= req_sel;
                end
            end
            if (state == ST_READ && expired) begin
                rd_data <= dq_in;
                done    <= 1'b1;
            end
            if (state == ST_WHOLD && expired) done <= 1'b1;
        end
    end

    always_comb begin
        case (state)
            ST_RD_OPEN, ST_READ: phase = PH_READ;
            ST_WSETUP, ST_WHOLD: phase = PH_ARM;
            ST_WPULSE:           phase = PH_PULSE;
            ST_WRECOV:           phase = PH_RECOV;
            default:             phase = PH_OFF;
        endcase
    end

    assign dq_oe = (state == ST_WPULSE) || (state == ST_WHOLD);

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && state != ST_RD_OPEN) |=> $stable(sel_q));

endmodule

// File: rtl/sram_ctl_pins.sv
module sram_ctl_pins
    import sram_ctl_pkg::*;
(
    input  wsel_e  sel,
    input  phase_e phase,
    output pins_t  pins
);

    always_comb pins = map_pins(sel, phase);

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter int ACC_CYC = 4,
    parameter int AS_CYC  = 2,
    parameter int WP_CYC  = 3,
    parameter int AH_CYC  = 1,
    parameter int WR_CYC  = 3,
    parameter int HZ_CYC  = 3,
    parameter int WC_CYC  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_wsel,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_ce,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int PR_W = $clog2(WP_CYC + 2);

    phase_e phase;
    wsel_e  sel_q;
    pins_t  pins;

    sram_ctl_fsm #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .ACC_CYC (ACC_CYC),
        .AS_CYC  (AS_CYC),
        .WP_CYC  (WP_CYC),
        .AH_CYC  (AH_CYC),
        .WR_CYC  (WR_CYC),
        .HZ_CYC  (HZ_CYC),
        .WC_CYC  (WC_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_sel   (wsel_e'(req_wsel)),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .dq_in     (mem_dq_in),
        .req_ready (req_ready),
        .phase     (phase),
        .sel_q     (sel_q),
        .addr_q    (mem_addr),
        .wdata_q   (mem_dq_out),
        .dq_oe     (mem_dq_oe),
        .done      (done),
        .rd_data   (rd_data)
    );

    sram_ctl_pins u_pins (
        .sel   (sel_q),
        .phase (phase),
        .pins  (pins)
    );

    assign mem_cs_n = pins.cs_n;
    assign mem_ce   = pins.ce;
    assign mem_we_n = pins.we_n;
    assign mem_oe_n = pins.oe_n;

    logic            wr_act;
    logic [PR_W-1:0] pulse_run;

    assign wr_act = !mem_cs_n && mem_ce && !mem_we_n;

    always_ff @(posedge clk) begin
        if (rst)         pulse_run <= '0;
        else if (wr_act) pulse_run <= pulse_run + 1'b1;
        else             pulse_run <= '0;
    end

    // R5
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_act) |-> (pulse_run == PR_W'(WP_CYC)));

    // R7
    bus_dir_chk: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n);

    // R2
    read_ctl_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (!mem_cs_n && mem_ce && mem_we_n));

    // R6
    addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        wr_act |-> $stable(mem_addr));

    // R7
    wdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

    // R7
    pulse_drive_chk: assert property (@(posedge clk) disable iff (rst)
        wr_act |-> mem_dq_oe);

endmodule

// File: tb/sram_ctl_tb.sv
module sram_ctl_tb;

    localparam int AW     = 8;
    localparam int DW     = 8;
    localparam int T_ACC  = 4;
    localparam int T_AS   = 2;
    localparam int T_WP   = 3;
    localparam int T_AH   = 1;
    localparam int T_WR   = 3;
    localparam int T_HZ   = 3;
    localparam int T_WC   = 10;
    localparam int NVEC   = 12;
    localparam logic [DW-1:0] POISON = 8'hEE;

    // {write, sel[1:0], addr[7:0], data[7:0]}; for reads data is the expected word
    localparam logic [18:0] VEC [NVEC] = '{
        {1'b1, 2'd0, 8'h10, 8'h3C},
        {1'b1, 2'd1, 8'h11, 8'h5A},
        {1'b1, 2'd2, 8'h12, 8'hC3},
        {1'b0, 2'd0, 8'h10, 8'h3C},
        {1'b0, 2'd0, 8'h11, 8'h5A},
        {1'b0, 2'd0, 8'h12, 8'hC3},
        {1'b1, 2'd3, 8'h10, 8'h77},
        {1'b0, 2'd0, 8'h10, 8'h77},
        {1'b1, 2'd1, 8'h20, 8'h01},
        {1'b1, 2'd2, 8'h21, 8'h02},
        {1'b0, 2'd0, 8'h21, 8'h02},
        {1'b0, 2'd0, 8'h20, 8'h01}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [1:0]    req_wsel = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, done;
    logic [DW-1:0] rd_data, mem_dq_out, mem_dq_in;
    logic [AW-1:0] mem_addr;
    logic          mem_cs_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int cur_sel = 0;

    always #4 clk = ~clk;

    sram_ctl #(
        .ADDR_W(AW), .DATA_W(DW), .ACC_CYC(T_ACC), .AS_CYC(T_AS), .WP_CYC(T_WP),
        .AH_CYC(T_AH), .WR_CYC(T_WR), .HZ_CYC(T_HZ), .WC_CYC(T_WC)
    ) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_wsel(req_wsel), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .done(done), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_ce(mem_ce),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [DW-1:0] mem [1 << AW];
    logic          rd_en, wr_en;
    int            age = 0;
    logic          prev_rd = 1'b0;
    logic [AW-1:0] prev_a = '0;

    assign rd_en = !mem_cs_n && mem_ce && mem_we_n && !mem_oe_n;
    assign wr_en = !mem_cs_n && mem_ce && !mem_we_n;
    assign mem_dq_in = (rd_en && (age + 2 >= T_ACC)) ? mem[mem_addr] : POISON;

    always @(posedge clk) begin
        if (rd_en && prev_rd && mem_addr == prev_a) age <= age + 1;
        else                                       age <= 0;
        prev_rd <= rd_en;
        prev_a  <= mem_addr;
        if (wr_en && mem_dq_oe) mem[mem_addr] <= mem_dq_out;
    end

    // ---------------- timing monitor ----------------
    int stab, plen, gap, post, rdoff, cyc, last_start, cs_rises, oe_rises;
    bit seen_pulse, had_read;
    logic p_cs_n, p_ce, p_we_n, p_act, p_oe, p_oe_n;
    logic [AW-1:0] p_addr, pulse_addr;

    always @(posedge clk) begin
        if (rst) begin
            stab = 0; plen = 0; gap = 0; post = 0; rdoff = 0; cyc = 0; last_start = 0;
            seen_pulse = 0; had_read = 0;
            p_cs_n = 1; p_ce = 0; p_we_n = 1; p_act = 0; p_oe = 0; p_oe_n = 1;
            p_addr = mem_addr; pulse_addr = '0;
        end else begin
            cyc++;
            stab = (mem_addr == p_addr) ? stab + 1 : 0;
            if (wr_en && !p_act) begin
                // R6 address setup before the pulse
                chk(stab >= T_AS, "R6 setup", stab, T_AS);
                // R4 pulse shape in the cycle before the pulse
                case (cur_sel)
                    1: chk(p_cs_n == 1 && p_ce == 1 && p_we_n == 0, "R4 cs-timed arm",
                           {p_cs_n, p_ce, p_we_n}, 3'b110);
                    2: chk(p_cs_n == 0 && p_ce == 0 && p_we_n == 0, "R4 ce-timed arm",
                           {p_cs_n, p_ce, p_we_n}, 3'b000);
                    default: chk(p_cs_n == 0 && p_ce == 1 && p_we_n == 1, "R4 we-timed arm",
                           {p_cs_n, p_ce, p_we_n}, 3'b011);
                endcase
                if (seen_pulse) begin
                    chk(gap >= T_WR, "R9 gap", gap, T_WR);
                    chk(cyc - last_start >= T_WC, "R9 cycle", cyc - last_start, T_WC);
                end
                last_start = cyc; seen_pulse = 1; plen = 0; pulse_addr = mem_addr;
            end
            if (wr_en) begin
                plen++; gap = 0;
                if (mem_addr != pulse_addr) chk(0, "R6 addr moved", mem_addr, pulse_addr);
            end else gap++;
            if (!wr_en && p_act) chk(plen == T_WP, "R5 width", plen, T_WP);
            if (mem_dq_oe && !p_oe) begin
                chk(wr_en, "R7 drive start", wr_en, 1);
                if (had_read) chk(rdoff >= T_HZ + T_AS, "R10 turnaround", rdoff, T_HZ + T_AS);
                had_read = 0; post = 0;
            end
            if (mem_dq_oe && !wr_en) post++;
            if (!mem_dq_oe && p_oe) begin
                chk(post == T_AH, "R7 hold", post, T_AH);
                if (cur_sel == 1 || cur_sel == 2)
                    chk(mem_cs_n == 1 && mem_ce == 0, "R8 released recovery",
                        {mem_cs_n, mem_ce, mem_we_n}, 3'b101);
                else
                    chk(mem_cs_n == 0 && mem_ce == 1 && mem_we_n == 1, "R8 selected recovery",
                        {mem_cs_n, mem_ce, mem_we_n}, 3'b011);
            end
            if (!mem_oe_n) begin had_read = 1; rdoff = 0; end
            else if (!mem_dq_oe) rdoff++;
            if (mem_cs_n && !p_cs_n) cs_rises++;
            if (mem_oe_n && !p_oe_n) oe_rises++;
            p_cs_n = mem_cs_n; p_ce = mem_ce; p_we_n = mem_we_n; p_act = wr_en;
            p_oe = mem_dq_oe; p_oe_n = mem_oe_n; p_addr = mem_addr;
        end
    end

    // ---------------- request tasks ----------------
    task automatic wait_ready();
        @(negedge clk);
        while (!req_ready) @(negedge clk);
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 200) begin @(negedge clk); n++; end
    endtask

    task automatic do_write(input logic [1:0] sel, input logic [AW-1:0] a, input logic [DW-1:0] d);
        wait_ready();
        cur_sel = sel;
        req_valid = 1; req_write = 1; req_wsel = sel; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0;
        wait_done();
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
        int n;
        wait_ready();
        req_valid = 1; req_write = 0; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        n = 0;
        while (!done && n < 200) begin @(negedge clk); n++; end
        chk(n == T_ACC, "R2 latency", n, T_ACC);
        chk(rd_data == exp, "R2 data", rd_data, exp);
        @(negedge clk);
        chk(done == 0, "R2 done width", done, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 50000, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk({mem_cs_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe, done} == 6'b101100,
            "R1 in reset", {mem_cs_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe, done}, 6'b101100);
        rst = 0;
        @(negedge clk);
        chk({mem_cs_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe, done, req_ready} == 7'b1011001,
            "R1 after reset", {mem_cs_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe, done, req_ready},
            7'b1011001);

        // Vector walk: R2, R4, R5, R6, R7, R8, R9, R10 via model and monitor
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][18]) do_write(VEC[i][17:16], VEC[i][15:8], VEC[i][7:0]);
            else            do_read(VEC[i][15:8], VEC[i][7:0]);
        end

        // R3 back-to-back reads keep the chip selected and the output enabled
        begin
            int cs0, oe0;
            cs0 = cs_rises; oe0 = oe_rises;
            do_read(8'h12, 8'hC3);
            do_read(8'h11, 8'h5A);
            chk(cs_rises == cs0, "R3 select held", cs_rises - cs0, 0);
            chk(oe_rises == oe0, "R3 output enable held", oe_rises - oe0, 0);
        end

        // R11 selector change after acceptance has no effect on the write shape
        wait_ready();
        cur_sel = 1;
        req_valid = 1; req_write = 1; req_wsel = 2'd1; req_addr = 8'h30; req_wdata = 8'h9D;
        @(negedge clk);
        req_valid = 0; req_wsel = 2'd2;
        wait_done();
        do_read(8'h30, 8'h9D);
        chk(mem[8'h30] == 8'h9D, "R11 stored word", mem[8'h30], 8'h9D);

        // R9 back-to-back writes with each timing control, then read back
        do_write(2'd2, 8'h40, 8'hA1);
        do_write(2'd0, 8'h41, 8'hB2);
        do_write(2'd1, 8'h42, 8'hC4);
        do_read(8'h40, 8'hA1);
        do_read(8'h41, 8'hB2);
        do_read(8'h42, 8'hC4);

        repeat (4) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule